// File: doc/BRIEF.md
# Grouped Interrupt Request Router

This block gathers sixteen active-low interrupt inputs from board devices and presents them to a processor as four shared request lines and one non-maskable line. Each input sets a pending flag. A mask register chooses which pending flags may reach the request lines. Software sees both registers on a small 16-bit register bus.

Inputs 0 to 14 are level-sensitive. Their flags are set on every clock while the input is held low, so a source that has not been serviced raises its request again as soon as software clears it. Input 15 serves a push button. It sets its flag once on each falling edge and drives the non-maskable line, which the mask does not affect.

Each of the four request lines is the OR of the unmasked pending flags in a fixed, sparse group of inputs. Input 0 only records a flag and drives no line. Every input passes through a synchroniser before it is sampled.

Top module: `intr_router`

## Requirements
- R1: After reset the mask register reads 0x7FFE, the flag register reads 0x0000, and `irq_out` and `nmi_out` are low.
- R2: The mask register sits at byte offset 0x4. It is read and written as a whole 16-bit word. A mask bit of 1 blocks the matching input from `irq_out`, and a 0 lets it through.
- R3: The flag register sits at byte offset 0xC. A write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. A read returns every pending flag whatever the mask holds. Any other offset reads 0.
- R4: Inputs 0 to 14 are active-low and level-sensitive. A flag whose input is still low is set again on the clock after a clear, so it reads back as set.
- R5: Input 15 sets flag 15 only on a falling edge. If the input stays low after the flag is cleared, the flag stays clear until the input goes high and then low again.
- R6: An input change reaches the flag on the third rising clock edge after it is applied. The first two edges pass through a two-stage synchroniser.
- R7: `irq_out[0]` is high when flag 3 or flag 5 is pending and unmasked. `irq_out[1]` covers bits 4 and 6. `irq_out[2]` covers bits 10, 11 and 12. `irq_out[3]` covers bits 1, 2, 7, 8, 9, 13 and 14.
- R8: Flags 0 and 15 never drive `irq_out`. `nmi_out` follows flag 15 whatever mask bit 15 holds, and stays high until software clears the flag.
- R9: When a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_n | input | 16 | Interrupt inputs, active low, asynchronous |
| irq_out | output | 4 | Grouped request lines, active high |
| nmi_out | output | 1 | Non-maskable request, active high |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, the mask register at offset 0x4 and the flag register at offset 0xC. With these values every routing group, the unrouted input 0 and the edge-triggered input 15 are all reachable from the ports. The fixed three-edge latency also allows a clearing write to be timed so that it lands in the same cycle as the edge on input 15. That timing is what lets the bench exercise the set-wins rule and the level re-assertion rule directly.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NUM_IN  = 16;
  localparam int NUM_OUT = 4;

  // Input membership of each request line; index = line number.
  localparam logic [NUM_OUT-1:0][NUM_IN-1:0] GROUP_SEL = {
    16'h6386,   // line 3
    16'h1C00,   // line 2
    16'h0050,   // line 1
    16'h0028    // line 0
  };

  // Live requests = pending and enabled; OR each group.
  function automatic logic [NUM_OUT-1:0] route_groups(
    input logic [NUM_IN-1:0] pend,
    input logic [NUM_IN-1:0] mask
  );
    logic [NUM_IN-1:0] live;
    live = pend & ~mask;
    for (int g = 0; g < NUM_OUT; g++) route_groups[g] = |(live & GROUP_SEL[g]);
  endfunction

  // Next flag value: kept bits survive a write, new events always win.
  function automatic logic [NUM_IN-1:0] next_flags(
    input logic [NUM_IN-1:0] cur,
    input logic              wr,
    input logic [NUM_IN-1:0] keep,
    input logic [NUM_IN-1:0] set_ev
  );
    next_flags = (wr ? (cur & keep) : cur) | set_ev;
  endfunction
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;                 // inactive level for active-low inputs
    end else begin
      pipe_q[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/intr_detect.sv
module intr_detect #(
  parameter int W        = 16,
  parameter int EDGE_BIT = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_n,
  output logic [W-1:0] set_ev
);
  logic edge_prev_q;
  logic edge_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev_q <= 1'b1;
    else        edge_prev_q <= sync_n[EDGE_BIT];
  end

  assign edge_fall = edge_prev_q & ~sync_n[EDGE_BIT];

  for (genvar i = 0; i < W; i++) begin : g_kind
    if (i == EDGE_BIT) begin : g_edge
      assign set_ev[i] = edge_fall;
    end else begin : g_level
      assign set_ev[i] = ~sync_n[i];
    end
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |=> !edge_fall);                                        // R5
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_pkg::*;
#(
  parameter logic [NUM_IN-1:0] MASK_RST = 16'h7FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              flag_wr,
  input  logic [NUM_IN-1:0] wdata,
  input  logic [NUM_IN-1:0] set_ev,
  output logic [NUM_IN-1:0] mask_q,
  output logic [NUM_IN-1:0] flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      flag_q <= '0;
    end else begin
      if (mask_wr) mask_q <= wdata;
      flag_q <= next_flags(flag_q, flag_wr, wdata, set_ev);
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));                                     // R2
  AST_FLAG_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));          // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_ev) |=> ((flag_q & $past(set_ev)) == $past(set_ev)));         // R9
endmodule

// File: rtl/intr_router.sv
module intr_router
  import intr_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] MASK_OFS    = 4'h4,
  parameter logic [ADDR_W-1:0] FLAG_OFS    = 4'hC,
  parameter logic [15:0]       MASK_RST    = 16'h7FFE,
  parameter int                NMI_BIT     = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata,
  input  logic [15:0]         irq_n,
  output logic [3:0]          irq_out,
  output logic                nmi_out
);
  localparam logic [NUM_IN-1:0] NMI_ONEHOT = NUM_IN'(1) << NMI_BIT;

  logic [NUM_IN-1:0] sync_n;
  logic [NUM_IN-1:0] set_ev;
  logic [NUM_IN-1:0] mask_q;
  logic [NUM_IN-1:0] flag_q;
  logic              mask_wr;
  logic              flag_wr;

  assign mask_wr = bus_wr && (bus_addr == MASK_OFS);
  assign flag_wr = bus_wr && (bus_addr == FLAG_OFS);

  intr_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_n), .dout(sync_n)
  );

  intr_detect #(.W(NUM_IN), .EDGE_BIT(NMI_BIT)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .set_ev(set_ev)
  );

  intr_regs #(.MASK_RST(MASK_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .flag_wr(flag_wr),
    .wdata(bus_wdata), .set_ev(set_ev), .mask_q(mask_q), .flag_q(flag_q)
  );

  always_comb begin
    if (bus_addr == MASK_OFS)      bus_rdata = mask_q;
    else if (bus_addr == FLAG_OFS) bus_rdata = flag_q;
    else                           bus_rdata = '0;
  end

  assign irq_out = route_groups(flag_q, mask_q);
  assign nmi_out = flag_q[NMI_BIT];

  AST_OUT_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_out) |-> (|(flag_q & ~mask_q & ~NMI_ONEHOT & ~NUM_IN'(1))));  // R7
  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_out) |-> $past(flag_wr));                                 // R8
endmodule

// File: tb/intr_router_bench.sv
module intr_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {active inputs, mask}
  localparam logic [NVEC-1:0][31:0] VEC = {
    {16'h7FFE, 16'h0000},
    {16'h7FFE, 16'h7FFE},
    {16'h8000, 16'hFFFF},
    {16'h0001, 16'h0000},
    {16'h2400, 16'h0000},
    {16'h0028, 16'h0020},
    {16'h0100, 16'h0000},
    {16'h0800, 16'h0000},
    {16'h0040, 16'h0000},
    {16'h0008, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [15:0] irq_n = 16'hFFFF;
  logic [3:0]  irq_out;
  logic        nmi_out;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_router u_intr_router (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n),
    .irq_out(irq_out), .nmi_out(nmi_out)
  );

  function automatic logic [3:0] expect_lines(logic [15:0] pend, logic [15:0] mask);
    logic [3:0] r = 4'b0;
    for (int i = 1; i <= 14; i++) begin
      if (pend[i] && !mask[i]) begin
        case (i)
          3, 5:       r[0] = 1'b1;
          4, 6:       r[1] = 1'b1;
          10, 11, 12: r[2] = 1'b1;
          default:    r[3] = 1'b1;
        endcase
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_read(4'h4, rd); check("R1 mask", rd, 16'h7FFE);
    bus_read(4'hC, rd); check("R1 flags", rd, 16'h0000);
    check("R1 lines", {11'b0, nmi_out, irq_out}, 16'h0);

    // R2 readback and unused offset (R3)
    bus_write(4'h4, 16'h1234);
    bus_read(4'h4, rd); check("R2 mask readback", rd, 16'h1234);
    bus_read(4'h8, rd); check("R3 unused offset", rd, 16'h0000);

    // vector table: R2 R3 R7 R8
    for (int v = NVEC - 1; v >= 0; v--) begin
      logic [15:0] act, msk;
      act = VEC[v][31:16]; msk = VEC[v][15:0];
      bus_write(4'h4, msk);
      irq_n = ~act;
      repeat (4) @(negedge clk);
      check("R7 lines", {12'b0, irq_out}, {12'b0, expect_lines(act, msk)});
      check("R8 nmi", {15'b0, nmi_out}, {15'b0, act[15]});
      bus_read(4'hC, rd); check("R3 raw flags", rd, act);
      irq_n = 16'hFFFF;
      repeat (4) @(negedge clk);
      bus_write(4'hC, 16'h0000);
      bus_read(4'hC, rd); check("R3 clear", rd, 16'h0000);
    end

    // R6 latency
    bus_write(4'h4, 16'h0000);
    irq_n[5] = 1'b0;
    @(negedge clk); @(negedge clk);
    bus_read(4'hC, rd); check("R6 not yet", rd, 16'h0000);
    @(negedge clk);
    bus_read(4'hC, rd); check("R6 third edge", rd, 16'h0020);

    // R4 level re-assertion after a clear
    bus_write(4'hC, 16'h0000);
    bus_read(4'hC, rd); check("R4 reasserted", rd, 16'h0020);
    check("R4 line0", {12'b0, irq_out}, 16'h0001);
    irq_n[5] = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(4'hC, 16'h0000);

    // R9 clear write lands on the edge set cycle
    bus_write(4'h4, 16'hFFFF);
    irq_n[15] = 1'b0;
    @(negedge clk); @(negedge clk);
    bus_addr = 4'hC; bus_wdata = 16'h0000; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 set wins", {15'b0, nmi_out}, 16'h1);

    // R3 write of ones keeps flags
    bus_write(4'hC, 16'hFFFF);
    check("R3 ones keep", {15'b0, nmi_out}, 16'h1);

    // R5 held low: no re-set after clear
    bus_write(4'hC, 16'h7FFF);
    repeat (4) @(negedge clk);
    bus_read(4'hC, rd); check("R5 held low stays clear", rd, 16'h0000);
    check("R8 nmi dropped", {15'b0, nmi_out}, 16'h0);
    irq_n[15] = 1'b1;
    repeat (4) @(negedge clk);
    irq_n[15] = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 new edge sets", {15'b0, nmi_out}, 16'h1);
    check("R8 masked nmi keeps lines low", {12'b0, irq_out}, 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule